// File: doc/BRIEF.md
# Z-Ordered Plane Priority Packer

The block turns a set of per-plane descriptors into a packed display priority word. Each of up to eight hardware planes presents a visible flag, a 4-bit depth value, a 3-bit hardware index and a flag for formats that occupy two hardware planes. After a start pulse, the block captures these descriptors. It inserts the visible planes one per cycle into a list kept in ascending depth order. It then walks the list, one entry per cycle, and packs each hardware index into 4-bit slots. The result also carries a bitmask of the hardware planes that were placed.

The packed word is written from the most significant used slot downward. The shallowest plane lands in the highest used nibble, and the deepest plane lands in bits 3:0. A two-plane format takes a second slot directly below its own, which names the next hardware plane with wrap-around. When the slots needed exceed the word, the block keeps the leading slots, drops the remainder and flags the overflow. A one-cycle done pulse marks a fresh result. The result is then held until the next run completes.

Top module: `plane_prio_packer`

## Requirements
- R1: Only planes whose visible flag is 1 contribute slots or mask bits; an invisible plane's depth, index and format flag have no effect on the result.
- R2: Visible planes are ordered by ascending depth. Planes with equal depth keep their plane-number order, lower plane number first. The first plane in that order occupies the most significant used slot.
- R3: Each slot is 4 bits and holds hardware index plus 1 (value 0 marks an empty slot). With S slots used (S at most 8), the slots fill bits 4*S-1 down to 0 in order, and all bits above 4*S-1 are 0.
- R4: A plane with the two-plane flag set takes a second slot immediately after its own (the next lower nibble), holding ((index+1) mod 8)+1.
- R5: Every slot placed sets bit (hardware index of that slot) in used_o; no other bit of used_o is set.
- R6: With no visible plane, prio_o and used_o are both 0 and ovf_o is 0.
- R7: If more than 8 slots are needed, ovf_o is 1. All 8 nibbles then hold the first 8 slots in order. The surplus slots appear neither in prio_o nor in used_o.
- R8: done_o is high for exactly one cycle. It rises NUM_PLANES+V+1 clock edges after the edge that accepts start_i, where V is the number of visible planes. busy_o is high from the accepting edge until done_o rises.
- R9: start_i while busy_o is high is ignored. prio_o, used_o and ovf_o keep the previous result until done_o rises.
- R10: After reset, prio_o, used_o, ovf_o, done_o and busy_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the plane descriptors when idle |
| vis_i | input | NUM_PLANES | Visible flag per plane |
| zpos_i | input | 4*NUM_PLANES | Depth per plane, plane p at bits 4p+3:4p |
| hwidx_i | input | 3*NUM_PLANES | Hardware index per plane, plane p at bits 3p+2:3p |
| dual_i | input | NUM_PLANES | Two-plane format flag per plane |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a new result is presented |
| prio_o | output | 4*NUM_SLOTS | Packed priority word |
| used_o | output | 8 | Mask of hardware planes placed |
| ovf_o | output | 1 | More slots were needed than the word holds |

## Verification
A corrupted sorted list shows up at the ports as nibbles out of depth order. It can also show as equal-depth planes swapped. Either fault appears on the very next done pulse, since the list is rebuilt from nothing on every run. A wrong slot counter or effective slot count shifts the whole word by a nibble. It can also leave a zero nibble inside the used range, or spill a slot past the top, together with a mismatched mask. A stuck control state shows as a done pulse arriving early, late or not at all against the NUM_PLANES+V+1 edge count.

// File: rtl/ppk_pkg.sv
package ppk_pkg;
  localparam int unsigned ZW = 4;
  localparam int unsigned IW = 3;
  localparam int unsigned SW = 4;
  localparam int unsigned HW_PLANES = 1 << IW;

  typedef struct packed {
    logic [ZW-1:0] z;
    logic [IW-1:0] idx;
    logic          dual;
  } ppk_ent_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INS  = 2'd1,
    ST_EMIT = 2'd2
  } ppk_state_e;
endpackage

// File: rtl/ppk_sorter.sv
module ppk_sorter
  import ppk_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           ins_i,
  input  ppk_ent_t       ent_i,
  input  logic [CW-1:0]  rd_ptr_i,
  output logic [IW-1:0]  rd_idx_o,
  output logic           rd_dual_o,
  output logic [CW-1:0]  count_o
);
  ppk_ent_t      ent_q [N];
  logic [CW-1:0] pos;

  // insertion point: after every stored entry with depth <= new depth (stable)
  always_comb begin
    pos = '0;
    for (int j = 0; j < N; j++)
      if (CW'(j) < count_o && ent_q[j].z <= ent_i.z) pos = pos + 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ent_q[g] <= '0;
        else if (ins_i && !clr_i && pos == '0) ent_q[g] <= ent_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ent_q[g] <= '0;
        else if (ins_i && !clr_i) begin
          if (CW'(g) == pos) ent_q[g] <= ent_i;
          else if (CW'(g) > pos && CW'(g) <= count_o) ent_q[g] <= ent_q[g-1];
        end
      end
      a_r2_ordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (CW'(g) < count_o) |-> (ent_q[g-1].z <= ent_q[g].z));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (clr_i)  count_o <= '0;
    else if (ins_i)  count_o <= count_o + 1'b1;
  end

  always_comb begin
    rd_idx_o  = '0;
    rd_dual_o = 1'b0;
    for (int j = 0; j < N; j++)
      if (CW'(j) == rd_ptr_i) begin
        rd_idx_o  = ent_q[j].idx;
        rd_dual_o = ent_q[j].dual;
      end
  end

  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && !clr_i) |=> (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/ppk_packer.sv
module ppk_packer
  import ppk_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned TW = 5,
  localparam int unsigned OW = NUM_SLOTS * SW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 place_i,
  input  logic [IW-1:0]        idx_i,
  input  logic                 dual_i,
  input  logic [TW-1:0]        eff_i,
  output logic [OW-1:0]        word_o,
  output logic [HW_PLANES-1:0] mask_o
);
  logic [TW-1:0]        k_q, k_n, p1, p2;
  logic [IW-1:0]        idx2;
  logic [SW-1:0]        val1, val2;
  logic                 ok1, ok2;
  logic [OW-1:0]        word_n;
  logic [HW_PLANES-1:0] mask_n;

  always_comb begin
    idx2   = idx_i + 1'b1;  // wraps modulo hardware plane count
    val1   = SW'(idx_i) + SW'(1);
    val2   = SW'(idx2) + SW'(1);
    ok1    = place_i && (k_q < eff_i);
    ok2    = place_i && dual_i && ((k_q + TW'(1)) < eff_i);
    p1     = eff_i - k_q - TW'(1);
    p2     = eff_i - k_q - TW'(2);
    word_n = word_o;
    mask_n = mask_o;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (ok1 && p1 == TW'(s)) word_n[s*SW +: SW] = val1;
      if (ok2 && p2 == TW'(s)) word_n[s*SW +: SW] = val2;
    end
    if (ok1) mask_n[idx_i] = 1'b1;
    if (ok2) mask_n[idx2]  = 1'b1;
    k_n = k_q;
    if (place_i) k_n = k_q + (dual_i ? TW'(2) : TW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q <= '0; word_o <= '0; mask_o <= '0;
    end else if (clr_i) begin
      k_q <= '0; word_o <= '0; mask_o <= '0;
    end else begin
      k_q <= k_n; word_o <= word_n; mask_o <= mask_n;
    end
  end

  a_r5_mask_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(mask_o) & ~mask_o) == '0));
  a_r4_slot_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (place_i && dual_i && !clr_i) |=> (k_q == $past(k_q) + TW'(2)));
endmodule

// File: rtl/plane_prio_packer.sv
module plane_prio_packer
  import ppk_pkg::*;
#(
  parameter int unsigned NUM_PLANES = 8,
  parameter int unsigned NUM_SLOTS  = 8,
  localparam int unsigned CW = $clog2(NUM_PLANES + 1),
  localparam int unsigned TW = $clog2(2 * NUM_PLANES + 1),
  localparam int unsigned OW = NUM_SLOTS * SW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NUM_PLANES-1:0]    vis_i,
  input  logic [NUM_PLANES*ZW-1:0] zpos_i,
  input  logic [NUM_PLANES*IW-1:0] hwidx_i,
  input  logic [NUM_PLANES-1:0]    dual_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [OW-1:0]            prio_o,
  output logic [HW_PLANES-1:0]     used_o,
  output logic                     ovf_o
);
  ppk_state_e           state_q;
  logic [CW-1:0]        cnt_q;
  logic [TW-1:0]        total_q, eff;
  logic [NUM_PLANES-1:0] vis_q;
  ppk_ent_t             cap_q [NUM_PLANES];
  ppk_ent_t             cur_ent;
  logic                 cur_vis;
  logic                 accept, ins, place, emit_end;
  logic [IW-1:0]        rd_idx;
  logic                 rd_dual;
  logic [CW-1:0]        count;
  logic [OW-1:0]        word;
  logic [HW_PLANES-1:0] mask;

  assign busy_o   = (state_q != ST_IDLE);
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign ins      = (state_q == ST_INS) && cur_vis;
  assign emit_end = (state_q == ST_EMIT) && (cnt_q == count);
  assign place    = (state_q == ST_EMIT) && !emit_end;
  assign eff      = (total_q > TW'(NUM_SLOTS)) ? TW'(NUM_SLOTS) : total_q;

  always_comb begin
    cur_ent = '0;
    cur_vis = 1'b0;
    for (int j = 0; j < NUM_PLANES; j++)
      if (CW'(j) == cnt_q) begin
        cur_ent = cap_q[j];
        cur_vis = vis_q[j];
      end
  end

  for (genvar g = 0; g < NUM_PLANES; g++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cap_q[g] <= '0;
      else if (accept) begin
        cap_q[g].z    <= zpos_i[g*ZW +: ZW];
        cap_q[g].idx  <= hwidx_i[g*IW +: IW];
        cap_q[g].dual <= dual_i[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      total_q <= '0;
      vis_q   <= '0;
      done_o  <= 1'b0;
      prio_o  <= '0;
      used_o  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          vis_q   <= vis_i;
          cnt_q   <= '0;
          total_q <= '0;
          state_q <= ST_INS;
        end
        ST_INS: begin
          if (cur_vis) total_q <= total_q + (cur_ent.dual ? TW'(2) : TW'(1));
          if (cnt_q == CW'(NUM_PLANES - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_EMIT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_EMIT: begin
          if (emit_end) begin
            prio_o  <= word;
            used_o  <= mask;
            ovf_o   <= (total_q > TW'(NUM_SLOTS));
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ppk_sorter #(.N(NUM_PLANES)) u_sorter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .ins_i     (ins),
    .ent_i     (cur_ent),
    .rd_ptr_i  (cnt_q),
    .rd_idx_o  (rd_idx),
    .rd_dual_o (rd_dual),
    .count_o   (count)
  );

  ppk_packer #(.NUM_SLOTS(NUM_SLOTS), .TW(TW)) u_packer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .place_i (place),
    .idx_i   (rd_idx),
    .dual_i  (rd_dual),
    .eff_i   (eff),
    .word_o  (word),
    .mask_o  (mask)
  );

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(prio_o) && $stable(used_o) && $stable(ovf_o)));
  a_r6_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && used_o == '0) |-> (prio_o == '0 && !ovf_o));
  a_r7_top_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (prio_o[OW-1 -: SW] != '0 && prio_o[SW-1:0] != '0));
endmodule

// File: tb/plane_prio_packer_test.sv
`timescale 1ns/1ps
module plane_prio_packer_test;
  localparam int NP = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  vis_i = '0;
  logic [31:0] zpos_i = '0;
  logic [23:0] hwidx_i = '0;
  logic [7:0]  dual_i = '0;
  logic        busy_o, done_o, ovf_o;
  logic [31:0] prio_o;
  logic [7:0]  used_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] last_w = '0;
  logic [7:0]  last_m = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk_i = ~clk_i;

  plane_prio_packer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .vis_i(vis_i),
    .zpos_i(zpos_i), .hwidx_i(hwidx_i), .dual_i(dual_i), .busy_o(busy_o),
    .done_o(done_o), .prio_o(prio_o), .used_o(used_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // R2 stable depth order, R3/R4 slot values, R5 mask, R7 truncation
  task automatic ref_model(input logic [7:0] v, input logic [31:0] z, input logic [23:0] ix,
                           input logic [7:0] d, output logic [31:0] w, output logic [7:0] m,
                           output logic o, output int nv);
    int ord[8];
    int sidx[16];
    int n, ns, eff;
    n = 0;
    for (int p = 0; p < NP; p++) begin
      if (v[p]) begin
        int j;
        j = n;
        while (j > 0 && z[ord[j-1]*4 +: 4] > z[p*4 +: 4]) begin
          ord[j] = ord[j-1];
          j--;
        end
        ord[j] = p;
        n++;
      end
    end
    ns = 0;
    for (int k = 0; k < n; k++) begin
      sidx[ns] = int'(ix[ord[k]*3 +: 3]);
      ns++;
      if (d[ord[k]]) begin
        sidx[ns] = (int'(ix[ord[k]*3 +: 3]) + 1) % 8;
        ns++;
      end
    end
    eff = (ns > 8) ? 8 : ns;
    o = (ns > 8);
    w = '0;
    m = '0;
    for (int s = 0; s < eff; s++) begin
      w[(eff-1-s)*4 +: 4] = 4'(sidx[s] + 1);
      m[sidx[s]] = 1'b1;
    end
    nv = n;
  endtask

  task automatic run(input logic [7:0] v, input logic [31:0] z, input logic [23:0] ix,
                     input logic [7:0] d, input bit poke);
    logic [31:0] ew;
    logic [7:0]  em;
    logic        eo;
    int          nv, lat;
    ref_model(v, z, ix, d, ew, em, eo, nv);
    @(negedge clk_i);
    vis_i = v; zpos_i = z; hwidx_i = ix; dual_i = d; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    chk(busy_o === 1'b1, "R8 busy after start", 32'(busy_o), 32'd1);
    chk(prio_o === last_w && used_o === last_m, "R9 result held while busy", prio_o, last_w);
    while (done_o !== 1'b1 && lat < 100) begin
      if (poke && lat == 2) begin
        start_i = 1'b1; vis_i = ~v; zpos_i = ~z; hwidx_i = ~ix; dual_i = ~d;
      end else if (poke && lat == 3) begin
        start_i = 1'b0; vis_i = v; zpos_i = z; hwidx_i = ix; dual_i = d;
      end
      @(negedge clk_i);
      lat++;
    end
    start_i = 1'b0;
    // done rises NP+V+1 edges after accept; counted here in negedges from the start drive
    chk(lat == NP + nv + 2, "R8 done latency", 32'(lat), 32'(NP + nv + 2));
    chk(prio_o === ew, "R2/R3/R4 priority word", prio_o, ew);
    chk(used_o === em, "R5 used mask", 32'(used_o), 32'(em));
    chk(ovf_o === eo, "R7 overflow flag", 32'(ovf_o), 32'(eo));
    if (v == '0) chk(prio_o === '0 && used_o === '0 && ovf_o === 1'b0, "R6 empty result", prio_o, 32'd0);
    if (poke) chk(prio_o === ew, "R9 start while busy ignored", prio_o, ew);
    @(negedge clk_i);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R8 done single cycle", 32'(done_o), 32'd0);
    last_w = ew;
    last_m = em;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] zd, zs;
    logic [23:0] ixp, ixr;
    for (int p = 0; p < NP; p++) begin
      zd[p*4 +: 4] = 4'(7 - p);
      zs[p*4 +: 4] = 4'd5;
      ixp[p*3 +: 3] = 3'(p);
      ixr[p*3 +: 3] = 3'(7 - p);
    end
    repeat (3) @(negedge clk_i);
    // R10 reset values
    chk(prio_o === '0 && used_o === '0 && ovf_o === 1'b0, "R10 reset outputs", prio_o, 32'd0);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R10 reset control", 32'({done_o, busy_o}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 nothing visible, invisible planes with dual set (R1)
    run(8'h00, zd, ixp, 8'hFF, 1'b0);
    // R2 equal depth keeps plane order
    run(8'hFF, zs, ixr, 8'h00, 1'b0);
    // R4 wrap: index 7 two-plane -> second slot value 1
    run(8'h01, 32'h0, 24'h7, 8'h01, 1'b0);
    chk(prio_o === 32'h0000_0081, "R4 wrap nibble", prio_o, 32'h81);
    // R7 all eight two-plane: sixteen slots needed
    run(8'hFF, zd, ixp, 8'hFF, 1'b1);
    // R1/R2/R3 sweep of visibility masks, single-plane formats
    for (int vm = 0; vm < 256; vm++) run(8'(vm), zd, ixp, 8'h00, (vm % 37) == 0);
    // R4/R7 sweep with every plane two-plane format
    for (int vm = 0; vm < 256; vm++) run(8'(vm), zs, ixr, 8'hFF, 1'b0);
    // mixed random patterns with depth ties
    for (int t = 0; t < 300; t++) begin
      logic [31:0] r1, r2, r3;
      r1 = rnd(); r2 = rnd(); r3 = rnd();
      run(r1[7:0], r2 & 32'h3333_3333, r3[23:0], r1[15:8], (t % 11) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule